// File: doc/BRIEF.md
# Keyed Debug Reset and Boundary-Scan Control

This block guards two debug controls behind write keys. The first register, the reset-command register, accepts a 16-bit key in the upper half of a bus word and a 4-bit command in the lowest nibble. When both match in a single write, the block drives an active-low reset pulse to the test access port. The command field then clears itself. A write with a wrong key or any other command leaves the port alone, and the nibble it carries is only stored for read-back.

The second register, the scan-control register, holds one level that turns boundary-scan control of the test access port off. It changes only on a full-word write whose upper half carries a second key. A write that leaves out any byte lane is ignored. Only power-on reset clears this level. The command register and the pulse generator sit on system reset, on power-on reset, and on an acknowledge that the test access port returns once its reset has taken effect.

Software reaches both registers through a one-cycle write strobe that carries a register select and byte strobes. A combinational read port returns the selected register.

Top module: `dbg_key_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 and byte strobes 3, 2 and 0 all set, carrying 0xDCAF in bits 31:16 and 4'b1010 in bits 3:0, starts a reset pulse: `tap_rst_n` is low in the cycle after the write edge.
- R2: A write to the command register whose key is not 0xDCAF, whose command is not 4'b1010, or that lacks byte strobe 3, 2 or 0 leaves `tap_rst_n` high.
- R3: Each accepted command holds `tap_rst_n` low for exactly PULSE_CYCLES clock cycles (default 2). It then returns high.
- R4: Writes to the command register while a pulse is in progress are ignored. They neither extend the pulse nor change the stored command nibble.
- R5: Reading the command register (`rd_sel`=0) returns the last nibble written with byte strobe 0 in bits 3:0. An accepted command clears it to 0. So does system reset. So does `tap_rst_ack`, which also wins over a write in the same cycle.
- R6: Bits 31:4 of the command register read back as 0 at all times, so the key is never visible.
- R7: A write with `wr_sel`=1 loads bit 0 into `bscan_dis` only when all four byte strobes are set (4'hF) and bits 31:16 equal 0xA5A5. Any other write leaves it unchanged. Reading with `rd_sel`=1 returns the level in bit 0 and zeros above it.
- R8: `bscan_dis`=1 means boundary-scan control is disabled and 0 means it is enabled. The level is cleared by power-on reset only; system reset leaves it as it was.
- R9: After reset, `tap_rst_n` is high, the command nibble reads 0 and `bscan_dis` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_rst_n | input | 1 | Power-on reset, asynchronous, active low; clears every register |
| sys_rst_n | input | 1 | System reset, asynchronous, active low; clears the command register and the pulse generator |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 is the reset-command register, 1 is the scan-control register |
| wr_strb | input | 4 | Byte-lane strobes; bit n qualifies data bits 8n+7:8n |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 is the command register, 1 is the scan-control register |
| rd_data | output | 32 | Combinational read data of the selected register |
| tap_rst_ack | input | 1 | The test access port acknowledges its reset; clears the command nibble |
| tap_rst_n | output | 1 | Active-low reset pulse to the test access port |
| bscan_dis | output | 1 | 1 disables boundary-scan control, 0 enables it |

## Verification
The assertions take for granted that `wr_en` lasts one cycle per access and that `wr_sel`, `wr_strb` and `wr_data` hold steady around the sampling edge. They also take for granted that `tap_rst_ack` never arrives in the cycle of an accepted command. The stimulus changes every input at the falling edge and drops `wr_en` after one cycle. It raises the acknowledge only while no write is pending, and it applies resets only between accesses, so the pulse-length property only ever sees pulses that ran to completion.

// File: rtl/dbg_key_pkg.sv
package dbg_key_pkg;

  localparam int WORD_W  = 32;
  localparam int KEY_W   = 16;
  localparam int CMD_W   = 4;
  localparam int LANES   = WORD_W / 8;

  // Command register: key in upper half, command nibble in bits 3:0.
  // Needs lanes 3 and 2 (key) and lane 0 (command).
  function automatic logic cmd_hit(input logic [KEY_W-1:0] key,
                                   input logic [CMD_W-1:0] cmd,
                                   input logic [LANES-1:0] strb,
                                   input logic [KEY_W-1:0] key_ref,
                                   input logic [CMD_W-1:0] cmd_ref);
    return strb[3] && strb[2] && strb[0] && (key == key_ref) && (cmd == cmd_ref);
  endfunction

  // Scan register: every lane must be written and the key must match.
  function automatic logic scan_hit(input logic [KEY_W-1:0] key,
                                    input logic [LANES-1:0] strb,
                                    input logic [KEY_W-1:0] key_ref);
    return (&strb) && (key == key_ref);
  endfunction

endpackage

// File: rtl/dbg_trst_cmd.sv
module dbg_trst_cmd
  import dbg_key_pkg::*;
#(
  parameter logic [KEY_W-1:0] CMD_KEY  = 16'hDCAF,
  parameter logic [CMD_W-1:0] CMD_CODE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [LANES-1:0] strb_i,
  input  logic             busy_i,
  input  logic             ack_i,
  output logic             accept_o,
  output logic [CMD_W-1:0] cmd_q_o
);

  logic wr_live;
  logic [CMD_W-1:0] cmd_q;

  assign wr_live  = wr_en_i && !busy_i;
  assign accept_o = wr_live && cmd_hit(key_i, cmd_i, strb_i, CMD_KEY, CMD_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cmd_q <= '0;
    else if (ack_i)                 cmd_q <= '0;
    else if (accept_o)              cmd_q <= '0;
    else if (wr_live && strb_i[0])  cmd_q <= cmd_i;
  end

  assign cmd_q_o = cmd_q;

  // R4
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !ack_i) |=> $stable(cmd_q));

endmodule

// File: rtl/dbg_trst_pulse.sv
module dbg_trst_pulse #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic tap_rst_n_o
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start_i)        left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy_o      = (left_q != '0);
  assign tap_rst_n_o = (left_q == '0);

  // Checker counter: length of the current low run, saturating.
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_run <= '0;
    else if (tap_rst_n_o)            low_run <= '0;
    else if (low_run != '1)          low_run <= low_run + 1'b1;
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tap_rst_n_o) |-> (low_run == RUN_W'(PULSE_CYCLES)));

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);

endmodule

// File: rtl/dbg_scan_ctl.sv
module dbg_scan_ctl
  import dbg_key_pkg::*;
#(
  parameter logic [KEY_W-1:0] SCAN_KEY = 16'hA5A5
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             bit_i,
  input  logic [LANES-1:0] strb_i,
  output logic             scan_wr_ok_o,
  output logic             bscan_dis_o
);

  logic dis_q;

  assign scan_wr_ok_o = wr_en_i && scan_hit(key_i, strb_i, SCAN_KEY);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             dis_q <= 1'b0;
    else if (scan_wr_ok_o)  dis_q <= bit_i;
  end

  assign bscan_dis_o = dis_q;

  // R7
  scan_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !scan_wr_ok_o |=> $stable(bscan_dis_o));

endmodule

// File: rtl/dbg_key_ctrl.sv
module dbg_key_ctrl
  import dbg_key_pkg::*;
#(
  parameter int                PULSE_CYCLES = 2,
  parameter logic [KEY_W-1:0]  CMD_KEY      = 16'hDCAF,
  parameter logic [CMD_W-1:0]  CMD_CODE     = 4'b1010,
  parameter logic [KEY_W-1:0]  SCAN_KEY     = 16'hA5A5
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  wr_strb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              tap_rst_ack,
  output logic              tap_rst_n,
  output logic              bscan_dis
);

  logic             sys_n;
  logic             cmd_wr, scan_wr;
  logic             accept_cmd, pulse_busy, scan_wr_ok;
  logic [CMD_W-1:0] cmd_nib;
  logic             unused_bits;

  assign sys_n       = sys_rst_n & por_rst_n;
  assign cmd_wr      = wr_en && !wr_sel;
  assign scan_wr     = wr_en && wr_sel;
  assign unused_bits = ^wr_data[15:CMD_W];

  dbg_trst_cmd #(.CMD_KEY(CMD_KEY), .CMD_CODE(CMD_CODE)) u_cmd (
    .clk      (clk),
    .rst_n    (sys_n),
    .wr_en_i  (cmd_wr),
    .key_i    (wr_data[WORD_W-1:WORD_W-KEY_W]),
    .cmd_i    (wr_data[CMD_W-1:0]),
    .strb_i   (wr_strb),
    .busy_i   (pulse_busy),
    .ack_i    (tap_rst_ack),
    .accept_o (accept_cmd),
    .cmd_q_o  (cmd_nib)
  );

  dbg_trst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk         (clk),
    .rst_n       (sys_n),
    .start_i     (accept_cmd),
    .busy_o      (pulse_busy),
    .tap_rst_n_o (tap_rst_n)
  );

  dbg_scan_ctl #(.SCAN_KEY(SCAN_KEY)) u_scan (
    .clk          (clk),
    .por_n        (por_rst_n),
    .wr_en_i      (scan_wr),
    .key_i        (wr_data[WORD_W-1:WORD_W-KEY_W]),
    .bit_i        (wr_data[0]),
    .strb_i       (wr_strb),
    .scan_wr_ok_o (scan_wr_ok),
    .bscan_dis_o  (bscan_dis)
  );

  always_comb begin
    if (rd_sel) rd_data = {{(WORD_W-1){1'b0}}, bscan_dis};
    else        rd_data = {{(WORD_W-CMD_W){1'b0}}, cmd_nib};
  end

  // R1
  accept_to_low_chk: assert property (@(posedge clk) disable iff (!sys_n)
    accept_cmd |=> !tap_rst_n);

  // R2
  low_needs_accept_chk: assert property (@(posedge clk) disable iff (!sys_n)
    $fell(tap_rst_n) |-> $past(accept_cmd));

  // R5
  ack_clears_cmd_chk: assert property (@(posedge clk) disable iff (!sys_n)
    tap_rst_ack |=> (rd_sel || rd_data[CMD_W-1:0] == '0));

  // R7
  scan_write_needs_key_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (scan_wr_ok) |-> (wr_sel && wr_strb == '1 && wr_data[WORD_W-1:WORD_W-KEY_W] == SCAN_KEY));

endmodule

// File: tb/dbg_key_ctrl_test.sv
`timescale 1ns/1ps
module dbg_key_ctrl_test;

  logic        clk = 1'b0;
  logic        por_rst_n = 1'b0, sys_rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, tap_rst_ack = 1'b0;
  logic [3:0]  wr_strb = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        tap_rst_n, bscan_dis;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_key_ctrl uut (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_strb(wr_strb), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tap_rst_ack(tap_rst_ack),
    .tap_rst_n(tap_rst_n), .bscan_dis(bscan_dis)
  );

  // {sel, strb, data, pulse expected, read-back expected}
  localparam int NV = 12;
  localparam logic [69:0] VECS [NV] = '{
    {1'b0, 4'hF, 32'hDCAF000A, 1'b1, 32'h0},  // R1 accepted, R5 cleared
    {1'b0, 4'hF, 32'hDCAE000A, 1'b0, 32'hA},  // R2 wrong key, nibble kept
    {1'b0, 4'hF, 32'hDCAF0005, 1'b0, 32'h5},  // R2 wrong command
    {1'b0, 4'h1, 32'hDCAF000A, 1'b0, 32'hA},  // R2 key lanes missing
    {1'b0, 4'hD, 32'hDCAF000A, 1'b1, 32'h0},  // R1 lanes 3,2,0 suffice
    {1'b1, 4'hF, 32'hA5A50001, 1'b0, 32'h1},  // R7 set
    {1'b1, 4'h3, 32'hA5A50000, 1'b0, 32'h1},  // R7 lower half ignored
    {1'b1, 4'hC, 32'hA5A50000, 1'b0, 32'h1},  // R7 upper half ignored
    {1'b1, 4'hF, 32'hA5A40000, 1'b0, 32'h1},  // R7 wrong key
    {1'b1, 4'hF, 32'hA5A50000, 1'b0, 32'h0},  // R7 clear
    {1'b1, 4'hF, 32'hDCAF000A, 1'b0, 32'h0},  // R2 command key on scan reg
    {1'b1, 4'hF, 32'hA5A5FFFE, 1'b0, 32'h0}   // R7 only bit 0 taken
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one write at a falling edge; returns at the falling edge after it.
  task automatic wr(input logic sel, input logic [3:0] strb, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_strb = strb; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0; wr_data = 32'h0;
  endtask

  // Counts low samples of tap_rst_n over n falling edges, starting with the current one.
  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int k = 0; k < n; k++) begin
      if (k != 0) @(negedge clk);
      if (!tap_rst_n) lows++;
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel; #0.5; v = rd_data;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int lows;
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 tap_rst_n", {31'b0, tap_rst_n}, 32'h1);
    rd(1'b0, v); check("R9 cmd", v, 32'h0);
    rd(1'b1, v); check("R9 bscan", v, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [69:0] e;
      e = VECS[i];
      wr(e[69], e[68:65], e[64:33]);
      count_low(4, lows);
      check(e[32] ? "R1/R3 pulse" : "R2 no pulse", lows, e[32] ? 32'd2 : 32'd0);
      rd(e[69], v);
      check(e[69] ? "R7 scan read" : "R5/R6 cmd read", v, e[31:0]);
      @(negedge clk);
    end

    // R4: second command during a pulse is ignored
    wr(1'b0, 4'hF, 32'hDCAF000A);
    @(negedge clk); wr_en = 1'b0;
    wr_en = 1'b1; wr_sel = 1'b0; wr_strb = 4'hF; wr_data = 32'hDCAF000A;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0;
    count_low(4, lows);
    check("R4 pulse not extended", lows, 32'd0);
    wr(1'b0, 4'hF, 32'hDCAF000A);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_strb = 4'hF; wr_data = 32'h12340007;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0;
    rd(1'b0, v); check("R4 nibble not stored during pulse", v, 32'h0);
    repeat (3) @(negedge clk);

    // R5 acknowledge clears the nibble, and wins over a write
    wr(1'b0, 4'h1, 32'h00000003);
    rd(1'b0, v); check("R5 nibble stored", v, 32'h3);
    tap_rst_ack = 1'b1;
    wr_en = 1'b1; wr_sel = 1'b0; wr_strb = 4'h1; wr_data = 32'h00000009;
    @(negedge clk);
    tap_rst_ack = 1'b0; wr_en = 1'b0; wr_strb = 4'h0;
    rd(1'b0, v); check("R5 ack clears", v, 32'h0);

    // R6 key never visible
    wr(1'b0, 4'hF, 32'hFFFFFFF6);
    rd(1'b0, v); check("R6 key reads 0", v, 32'h6);

    // R8 system reset clears nibble but not scan level
    wr(1'b1, 4'hF, 32'hA5A50001);
    wr(1'b0, 4'h1, 32'h00000004);
    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1; @(negedge clk);
    rd(1'b0, v); check("R5 sys reset clears nibble", v, 32'h0);
    check("R8 sys reset keeps bscan_dis", {31'b0, bscan_dis}, 32'h1);
    por_rst_n = 1'b0; @(negedge clk); por_rst_n = 1'b1; @(negedge clk);
    check("R8 por clears bscan_dis", {31'b0, bscan_dis}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule